// File: doc/BRIEF.md
# Mirrored-Array Memory Front End with Parity Fallback

This block sits between a processor and two identical word arrays that mirror each other. Every processor write lands in both arrays in the same cycle, each word stored with an odd-parity bit. Every read fetches the addressed word from both arrays at once into a separate holding register per array, where its parity is checked. One array is the prime unit and the other is the backup. Reads behave like a destructive core read, so each read finishes by writing a word back to both arrays.

When the prime copy is clean, its data is returned and written back to both arrays. This quietly repairs a damaged backup copy. When only the prime copy is damaged, the block spends one extra cycle. It returns the backup data, rewrites both arrays with that good word, and swaps the prime and backup roles. It also raises a one-cycle correction flag and advances a saturating counter. When both copies are damaged, the block returns the prime data with an uncorrectable flag and leaves the roles unchanged. A fault-injection port flips any single stored bit, so tests can create the faults on purpose.

Top module: `dupmem_ctrl`

## Requirements
- R1: After reset, req_ready_o is high, rsp_valid_o is low, prime_sel_o is 0 (array A is prime), corr_count_o is 0, and every word reads back as zero with no error flag.
- R2: A write accepted while req_ready_o is high is stored in both arrays in one cycle. The stored word is the data plus a parity bit in position DATA_W chosen so that the total number of ones is odd. A write produces no response, and req_ready_o is high again on the next cycle.
- R3: When a read is accepted, both arrays are read in the same cycle into one holding register per array. If the prime copy has odd parity, rsp_valid_o is high with the prime data in the cycle after acceptance. req_ready_o is low for exactly that one cycle.
- R4: Every read ends by writing the returned word back to both arrays. As a result, a parity fault in the backup copy alone is repaired with no flag raised.
- R5: If the prime copy fails parity and the backup passes, the response comes in the second cycle after acceptance. It carries the backup data with err_corrected_o high, and req_ready_o is low for both cycles.
- R6: A correction writes the backup word into both arrays, so the next read of that address is clean.
- R7: A correction inverts prime_sel_o at the end of the response cycle.
- R8: corr_count_o rises by one for each correction and holds at its maximum value.
- R9: If both copies fail parity, the response comes in the cycle after acceptance with the prime data and err_uncorrectable_o high. prime_sel_o and corr_count_o do not change, and each array keeps its own stored word, so a repeated read flags again.
- R10: A pulse on inj_en_i inverts bit inj_bit_i (0..DATA_W-1 are data bits, DATA_W is the parity bit) of word inj_addr_i in array inj_array_i (0 = A, 1 = B). If the same word is written on the same edge, the inversion is applied on top of the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word address |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | Request accepted on this edge when high |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | DATA_W | Read data |
| err_corrected_o | output | 1 | Response was recovered from the backup copy |
| err_uncorrectable_o | output | 1 | Both copies failed parity |
| prime_sel_o | output | 1 | Current prime array (0 = A, 1 = B) |
| corr_count_o | output | CNT_W | Saturating count of corrections |
| inj_en_i | input | 1 | Fault-injection strobe |
| inj_array_i | input | 1 | Array to disturb (0 = A, 1 = B) |
| inj_addr_i | input | ADDR_W | Word to disturb |
| inj_bit_i | input | $clog2(DATA_W+1) | Bit position to invert |

## Verification
Fault injection and the restore write of a read can hit the same word on the same clock edge. This happens because the write-back of a clean read lands on the edge that ends the evaluation cycle. The bench provokes this by pulsing the injection port during the evaluation cycle of a clean read of the prime array's word. That read must still return clean data. The following read must then report a correction with the original data, which shows the flipped bit survived on top of the restored word and was not overwritten by it.

// File: rtl/dupmem_pkg.sv
package dupmem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_FIX  = 2'd2
  } dm_state_e;

  typedef enum logic [1:0] {
    V_PRIME_OK   = 2'd0,
    V_USE_BACKUP = 2'd1,
    V_BOTH_BAD   = 2'd2
  } dm_verdict_e;

endpackage

// File: rtl/dupmem_array.sv
module dupmem_array #(
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 4,
  localparam int WORD_W = DATA_W + 1,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_word_i,
  input  logic              inj_en_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [BIT_W-1:0]  inj_bit_i
);

  // zero data with its odd-parity bit set
  localparam logic [WORD_W-1:0] RST_WORD = WORD_W'(1) << DATA_W;

  logic [DEPTH-1:0][WORD_W-1:0] mem_q, mem_d;
  logic [WORD_W-1:0]            flip_mask;

  assign flip_mask = WORD_W'(1) << inj_bit_i;

  // next state: write first, then any injected inversion on top
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      mem_d[i] = mem_q[i];
      if (we_i && (wr_addr_i == ADDR_W'(i))) mem_d[i] = wr_word_i;
      if (inj_en_i && (inj_addr_i == ADDR_W'(i))) mem_d[i] = mem_d[i] ^ flip_mask;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= RST_WORD;
    end else if (we_i || inj_en_i) begin
      mem_q <= mem_d;
    end
  end

  assign rd_word_o = mem_q[rd_addr_i];

  // R2: a word written with odd parity and no disturbance keeps odd parity
  a_r2_stored_odd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !inj_en_i && (^wr_word_i)) |=> (^mem_q[$past(wr_addr_i)]));

endmodule

// File: rtl/dupmem_path.sv
module dupmem_path #(
  parameter int WORD_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] buf_o,
  output logic              par_ok_o
);

  logic [WORD_W-1:0] buf_q, buf_d;

  assign buf_d = capture_i ? word_i : buf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        buf_q <= '0;
    else if (capture_i) buf_q <= buf_d;
  end

  assign buf_o    = buf_q;
  assign par_ok_o = ^buf_q;

  // R3: the holding register keeps its word while a read is being resolved
  a_r3_buf_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !capture_i |=> $stable(buf_q));

endmodule

// File: rtl/dupmem_select.sv
module dupmem_select
  import dupmem_pkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic              prime_sel_i,
  input  logic [WORD_W-1:0] word_a_i,
  input  logic [WORD_W-1:0] word_b_i,
  input  logic              ok_a_i,
  input  logic              ok_b_i,
  output logic [WORD_W-1:0] prime_word_o,
  output logic [WORD_W-1:0] backup_word_o,
  output dm_verdict_e       verdict_o
);

  logic prime_ok, backup_ok;

  always_comb begin
    prime_word_o  = prime_sel_i ? word_b_i : word_a_i;
    backup_word_o = prime_sel_i ? word_a_i : word_b_i;
    prime_ok      = prime_sel_i ? ok_b_i : ok_a_i;
    backup_ok     = prime_sel_i ? ok_a_i : ok_b_i;
    if (prime_ok)       verdict_o = V_PRIME_OK;
    else if (backup_ok) verdict_o = V_USE_BACKUP;
    else                verdict_o = V_BOTH_BAD;
  end

endmodule

// File: rtl/dupmem_ctrl.sv
module dupmem_ctrl
  import dupmem_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 4,
  parameter  int CNT_W  = 8,
  localparam int WORD_W = DATA_W + 1,
  localparam int BIT_W  = $clog2(WORD_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_corrected_o,
  output logic              err_uncorrectable_o,
  output logic              prime_sel_o,
  output logic [CNT_W-1:0]  corr_count_o,
  input  logic              inj_en_i,
  input  logic              inj_array_i,
  input  logic [ADDR_W-1:0] inj_addr_i,
  input  logic [BIT_W-1:0]  inj_bit_i
);

  // reset: asserted at once, released on the second clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  dm_state_e                 state_q, state_d;
  logic                      prime_q, prime_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic [ADDR_W-1:0]         addr_q, addr_d;
  logic                      accept_rd, accept_wr;
  logic [1:0][WORD_W-1:0]    rd_word, buf_word, wr_word;
  logic [1:0]                par_ok, we;
  logic [ADDR_W-1:0]         wr_addr;
  logic [WORD_W-1:0]         prime_word, backup_word, new_word;
  dm_verdict_e               verdict;

  assign req_ready_o = rst_n && (state_q == ST_IDLE);
  assign accept_rd   = req_ready_o && req_valid_i && !req_write_i;
  assign accept_wr   = req_ready_o && req_valid_i && req_write_i;
  assign new_word    = {~^req_wdata_i, req_wdata_i};

  for (genvar g = 0; g < 2; g++) begin : g_unit
    logic inj_hit;
    assign inj_hit = inj_en_i && (inj_array_i == 1'(g));

    dupmem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk_i      (clk_i),
      .rst_ni     (rst_n),
      .rd_addr_i  (req_addr_i),
      .rd_word_o  (rd_word[g]),
      .we_i       (we[g]),
      .wr_addr_i  (wr_addr),
      .wr_word_i  (wr_word[g]),
      .inj_en_i   (inj_hit),
      .inj_addr_i (inj_addr_i),
      .inj_bit_i  (inj_bit_i)
    );

    dupmem_path #(.WORD_W(WORD_W)) u_path (
      .clk_i     (clk_i),
      .rst_ni    (rst_n),
      .capture_i (accept_rd),
      .word_i    (rd_word[g]),
      .buf_o     (buf_word[g]),
      .par_ok_o  (par_ok[g])
    );
  end

  dupmem_select #(.WORD_W(WORD_W)) u_select (
    .prime_sel_i   (prime_q),
    .word_a_i      (buf_word[0]),
    .word_b_i      (buf_word[1]),
    .ok_a_i        (par_ok[0]),
    .ok_b_i        (par_ok[1]),
    .prime_word_o  (prime_word),
    .backup_word_o (backup_word),
    .verdict_o     (verdict)
  );

  // next state and outputs
  always_comb begin
    state_d             = state_q;
    prime_d             = prime_q;
    cnt_d               = cnt_q;
    addr_d              = addr_q;
    we                  = '0;
    wr_word             = {new_word, new_word};
    wr_addr             = addr_q;
    rsp_valid_o         = 1'b0;
    rsp_rdata_o         = prime_word[DATA_W-1:0];
    err_corrected_o     = 1'b0;
    err_uncorrectable_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        wr_addr = req_addr_i;
        if (accept_wr) we = 2'b11;
        if (accept_rd) begin
          addr_d  = req_addr_i;
          state_d = ST_EVAL;
        end
      end
      ST_EVAL: begin
        unique case (verdict)
          V_PRIME_OK: begin
            rsp_valid_o = 1'b1;
            we          = 2'b11;
            wr_word     = {prime_word, prime_word};
            state_d     = ST_IDLE;
          end
          V_USE_BACKUP: begin
            state_d = ST_FIX;
          end
          default: begin
            // both copies bad: each array restores its own word
            rsp_valid_o         = 1'b1;
            err_uncorrectable_o = 1'b1;
            we                  = 2'b11;
            wr_word             = buf_word;
            state_d             = ST_IDLE;
          end
        endcase
      end
      ST_FIX: begin
        rsp_valid_o     = 1'b1;
        rsp_rdata_o     = backup_word[DATA_W-1:0];
        err_corrected_o = 1'b1;
        we              = 2'b11;
        wr_word         = {backup_word, backup_word};
        prime_d         = !prime_q;
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        state_d         = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      prime_q <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_FIX) prime_q <= prime_d;
      if (state_q == ST_FIX) cnt_q   <= cnt_d;
      if (accept_rd)         addr_q  <= addr_d;
    end
  end

  assign prime_sel_o  = prime_q;
  assign corr_count_o = cnt_q;

  // R3: no request is taken while a response is on the port
  a_r3_busy_while_rsp: assert property (@(posedge clk_i) disable iff (!rst_n)
    rsp_valid_o |-> !req_ready_o);
  // R5: a correction flag always comes with a response
  a_r5_corr_has_rsp: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_corrected_o |-> rsp_valid_o);
  // R9: uncorrectable never coincides with corrected
  a_r9_uncorr_alone: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_uncorrectable_o |-> (rsp_valid_o && !err_corrected_o));
  // R7: roles swap after a correction
  a_r7_role_swap: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_corrected_o |=> (prime_sel_o != $past(prime_sel_o)));
  // R9: roles kept after a double fault
  a_r9_role_kept: assert property (@(posedge clk_i) disable iff (!rst_n)
    err_uncorrectable_o |=> $stable(prime_sel_o));
  // R8: counter steps by one below its ceiling
  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_n)
    (err_corrected_o && (corr_count_o != '1)) |=> (corr_count_o == $past(corr_count_o) + 1'b1));
  // R8: counter quiet without a correction
  a_r8_count_quiet: assert property (@(posedge clk_i) disable iff (!rst_n)
    !err_corrected_o |=> $stable(corr_count_o));

endmodule

// File: tb/dupmem_ctrl_tb.sv
module dupmem_ctrl_tb_top;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int CW = 4;
  localparam int WW = DW + 1;
  localparam int BW = $clog2(WW);
  localparam int NW = 1 << AW;

  logic          clk, rst_n;
  logic          req_valid, req_write;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_ready, rsp_valid, corr, uncorr, prime_sel;
  logic [DW-1:0] rsp_rdata;
  logic [CW-1:0] corr_count;
  logic          inj_en, inj_array;
  logic [AW-1:0] inj_addr;
  logic [BW-1:0] inj_bit;

  dupmem_ctrl #(.DATA_W(DW), .ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .rsp_valid_o(rsp_valid),
    .rsp_rdata_o(rsp_rdata), .err_corrected_o(corr), .err_uncorrectable_o(uncorr),
    .prime_sel_o(prime_sel), .corr_count_o(corr_count),
    .inj_en_i(inj_en), .inj_array_i(inj_array), .inj_addr_i(inj_addr), .inj_bit_i(inj_bit)
  );

  initial clk = 1'b0;
  always #10ns clk = ~clk;

  // reference model built from the requirements
  logic [WW-1:0] ma [NW];
  logic [WW-1:0] mb [NW];
  bit            role;
  int            cnt_m;
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 0;

  logic [DW-1:0] eq_d [$];
  bit            eq_c [$];
  bit            eq_u [$];
  string         eq_t [$];

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare every response against the scoreboard
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (eq_d.size() == 0) begin
        check(1'b0, "R3", "unexpected response", int'(rsp_rdata), 0);
      end else begin
        logic [DW-1:0] ed;
        bit ec, eu;
        string et;
        ed = eq_d.pop_front();
        ec = eq_c.pop_front();
        eu = eq_u.pop_front();
        et = eq_t.pop_front();
        check(rsp_rdata == ed && corr == ec && uncorr == eu, et, "response {data,corr,uncorr}",
              int'({rsp_rdata, corr, uncorr}), int'({ed, ec, eu}));
      end
    end
  end

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    ma[a] = {~^d, d};
    mb[a] = {~^d, d};
    check(req_ready && !rsp_valid, "R2", "ready/no response after write",
          int'({req_ready, rsp_valid}), 2);
  endtask

  task automatic do_inject(input bit arr, input logic [AW-1:0] a, input int b);
    inj_en = 1'b1; inj_array = arr; inj_addr = a; inj_bit = BW'(b);
    @(negedge clk);
    inj_en = 1'b0;
    if (arr) mb[a] = mb[a] ^ (WW'(1) << b);
    else     ma[a] = ma[a] ^ (WW'(1) << b);
  endtask

  // read; optionally inject into a word during the evaluation cycle (R10)
  task automatic do_read(input logic [AW-1:0] a, input string tag,
                         input bit inj = 1'b0, input bit ia = 1'b0, input int ib = 0);
    logic [WW-1:0] pw, bw;
    int lat_exp, lat;
    pw = role ? mb[a] : ma[a];
    bw = role ? ma[a] : mb[a];
    if (^pw) begin
      eq_d.push_back(pw[DW-1:0]); eq_c.push_back(1'b0); eq_u.push_back(1'b0);
      lat_exp = 1;
    end else if (^bw) begin
      eq_d.push_back(bw[DW-1:0]); eq_c.push_back(1'b1); eq_u.push_back(1'b0);
      lat_exp = 2;
    end else begin
      eq_d.push_back(pw[DW-1:0]); eq_c.push_back(1'b0); eq_u.push_back(1'b1);
      lat_exp = 1;
    end
    eq_t.push_back(tag);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (inj) begin
      inj_en = 1'b1; inj_array = ia; inj_addr = a; inj_bit = BW'(ib);
    end
    lat = 0;
    while (!req_ready && lat < 8) begin
      lat++;
      @(negedge clk);
      inj_en = 1'b0;
    end
    inj_en = 1'b0;
    check(lat == lat_exp, tag, "ready-low cycles", lat, lat_exp);
    if (^pw) begin
      ma[a] = pw; mb[a] = pw;
    end else if (^bw) begin
      ma[a] = bw; mb[a] = bw;
      role = !role;
      if (cnt_m < (1 << CW) - 1) cnt_m++;
    end
    if (inj) begin
      if (ia) mb[a] = mb[a] ^ (WW'(1) << ib);
      else    ma[a] = ma[a] ^ (WW'(1) << ib);
    end
  endtask

  task automatic check_state(input string tag);
    check(prime_sel == role, tag, "prime_sel", int'(prime_sel), int'(role));
    check(int'(corr_count) == cnt_m, tag, "corr_count", int'(corr_count), cnt_m);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    inj_en = 1'b0; inj_array = 1'b0; inj_addr = '0; inj_bit = '0;
    for (int i = 0; i < NW; i++) begin
      ma[i] = WW'(1) << DW;
      mb[i] = WW'(1) << DW;
    end
    role = 1'b0; cnt_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    check(req_ready && !rsp_valid, "R1", "ready/rsp after reset", int'({req_ready, rsp_valid}), 2);
    check_state("R1");
    do_read(4'd3, "R1");

    // R2 / R3: plain writes and reads
    do_write(4'd1, 16'hA5A5);
    do_write(4'd2, 16'h0001);
    do_write(4'd7, 16'hFFFF);
    do_read(4'd1, "R3");
    do_read(4'd2, "R3");
    do_read(4'd7, "R2");

    // R4: backup-only fault repaired silently by the read write-back
    do_write(4'd5, 16'h1234);
    do_inject(1'b1, 4'd5, 2);
    do_read(4'd5, "R4");
    check_state("R4");
    // R5: prime fault now recovered from the repaired backup
    do_inject(1'b0, 4'd5, 7);
    do_read(4'd5, "R5");
    check_state("R7");
    // R6: both copies rewritten
    do_read(4'd5, "R6");
    // parity-bit fault on the new prime (B)
    do_inject(1'b1, 4'd5, DW);
    do_read(4'd5, "R5");
    check_state("R8");

    // R9: double fault
    do_write(4'd9, 16'h0F0F);
    do_inject(1'b0, 4'd9, 0);
    do_inject(1'b1, 4'd9, 1);
    do_read(4'd9, "R9");
    check_state("R9");
    do_read(4'd9, "R9");
    do_write(4'd9, 16'h3C3C);
    do_read(4'd9, "R2");

    // R10: injection on the same edge as the restore write
    do_write(4'd11, 16'hBEEF);
    do_read(4'd11, "R10", 1'b1, role, 4);
    do_read(4'd11, "R10");
    check_state("R10");

    // R8: saturation
    for (int k = 0; k < 16; k++) begin
      do_inject(role, 4'd2, k % DW);
      do_read(4'd2, "R8");
    end
    check_state("R8");

    repeat (2) @(negedge clk);
    check(eq_d.size() == 0, "R3", "responses outstanding", eq_d.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule